// File: doc/BRIEF.md
# Register-Programmed Watchdog Timer

This block is a countdown watchdog set up through one 8-bit control register on a simple write/read register port. The control byte packs three fields: an output-steering bit, a 5-bit reload count and a 2-bit tick-rate code. Every write of a nonzero count to the control register re-arms the countdown from that value. Writing a zero count stops the watchdog. Software keeps the watchdog alive by rewriting the register before the count runs out.

The countdown advances only on one of four low-frequency tick strobes. The rate code picks which strobe. On the tick that takes the count to zero, the block latches an expiry flag in a status register and stops counting. It then raises either an interrupt or a reset output, chosen by the steering bit, as a pulse that lasts one tick period. Software clears the flag by writing the status register. The tick sources and the bus protocol lie outside the block.

Top module: `wdog_regblk`

## Requirements
- R1: After reset, both outputs are low, the status flag is clear, the control register reads 0x00 and the watchdog is disarmed, so no strobe activity causes an expiry.
- R2: The control register sits at address 0x1B and reads back the last byte written to it. Its fields are: bit 7 steering (1 selects the reset output, 0 the interrupt), bits 6:2 the count, bits 1:0 the rate code.
- R3: A control write with a nonzero count N restarts the countdown from N, discarding any count in progress. Expiry happens on the Nth selected strobe after that write, and not before.
- R4: A control write with a zero count disarms the watchdog, and no number of strobes afterwards causes an expiry.
- R5: The countdown decrements only in cycles where tick_stb[code] is high, with code being the rate field (code 2 is the 1 Hz input). Strobes on the other three lines are ignored.
- R6: Expiry sets bit 5 of the status register at address 0x0F and stops the countdown. The flag stays set and no second expiry occurs until the watchdog is re-armed.
- R7: A write to the status register with bit 5 = 0 clears the flag, and a write with bit 5 = 1 leaves it unchanged. An expiry in the same cycle as a clearing write leaves the flag set.
- R8: From the cycle after the expiry edge, the output chosen by the steering bit sampled at expiry is high. It stays high until the next selected strobe edge, so a later control write does not change which output is driven. The other output stays low.
- R9: A control write that coincides with a selected strobe reloads the count and performs no decrement in that cycle.
- R10: Writes to any address other than 0x1B and 0x0F change no state, and reads of other addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read data (combinational) |
| tick_stb | input | 4 | Tick strobes, one per rate code |
| irq_o | output | 1 | Interrupt pulse on expiry (steering bit 0) |
| rst_o | output | 1 | Reset pulse on expiry (steering bit 1) |

## Verification
The bound checker follows the counter on every cycle. It checks that a nonzero-count write loads the count and arms the watchdog, and that a zero-count write disarms it. It checks that the count holds when no selected strobe or write arrives, and that the flag rises only out of an armed count of one on a selected strobe. It also checks that a clearing status write drops the flag, that a stopped watchdog stays stopped without a write, and that an output pulse begins only out of an armed state. The bench covers what needs whole scenarios. It sweeps every count, rate code and steering value to check the exact tick of expiry, the ignoring of the other strobe lines, and the pulse width. It also covers the priority cases: a write against a strobe, expiry against a status clear, steering that changes during a pulse, and stray addresses.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int DATA_W    = 8;
    localparam int CNT_W     = 5;
    localparam int RATE_W    = 2;
    localparam int NUM_TICKS = 1 << RATE_W;
    localparam int CNT_LSB   = RATE_W;
    localparam int EXP_BIT   = 5;

    // Control byte layout: steering on top, count in the middle, rate code low.
    typedef struct packed {
        logic              steer_rst;
        logic [CNT_W-1:0]  count;
        logic [RATE_W-1:0] rate;
    } wdog_ctrl_t;

    function automatic wdog_ctrl_t to_ctrl(input logic [DATA_W-1:0] b);
        return wdog_ctrl_t'(b);
    endfunction

    function automatic logic [DATA_W-1:0] status_byte(input logic flag);
        logic [DATA_W-1:0] v;
        v = '0;
        v[EXP_BIT] = flag;
        return v;
    endfunction
endpackage

// File: rtl/wdog_regfile.sv
module wdog_regfile
    import wdog_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h1B,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h0F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              flag_q,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_ctrl,
    output logic              wr_stat,
    output logic              stat_keep,
    output wdog_ctrl_t        new_ctrl,
    output wdog_ctrl_t        ctrl_q
);
    assign wr_ctrl   = wr_en && (wr_addr == CTRL_ADDR);
    assign wr_stat   = wr_en && (wr_addr == STAT_ADDR);
    assign stat_keep = wr_data[EXP_BIT];
    assign new_ctrl  = to_ctrl(wr_data);

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (wr_ctrl)
            ctrl_q <= new_ctrl;
    end

    always_comb begin
        if (rd_addr == CTRL_ADDR)
            rd_data = ctrl_q;
        else if (rd_addr == STAT_ADDR)
            rd_data = status_byte(flag_q);
        else
            rd_data = '0;
    end
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown
    import wdog_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_ctrl,
    input  logic [CNT_W-1:0]     load_cnt,
    input  logic [RATE_W-1:0]    rate,
    input  logic [NUM_TICKS-1:0] tick_stb,
    output logic                 armed,
    output logic [CNT_W-1:0]     cnt_q,
    output logic                 tick_sel,
    output logic                 expire
);
    logic [NUM_TICKS-1:0] hit;

    for (genvar g = 0; g < NUM_TICKS; g++) begin : g_tick
        assign hit[g] = tick_stb[g] && (rate == RATE_W'(g));
    end

    assign tick_sel = |hit;
    assign expire   = armed && tick_sel && !wr_ctrl && (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            cnt_q <= '0;
        end else if (wr_ctrl) begin
            armed <= |load_cnt;
            cnt_q <= load_cnt;
        end else if (armed && tick_sel) begin
            cnt_q <= cnt_q - CNT_W'(1);
            if (cnt_q == CNT_W'(1))
                armed <= 1'b0;
        end
    end
endmodule

// File: rtl/wdog_expiry_out.sv
module wdog_expiry_out (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic tick_sel,
    input  logic steer_rst,
    input  logic wr_stat,
    input  logic stat_keep,
    output logic flag_q,
    output logic irq_o,
    output logic rst_o
);
    logic pulse_q;
    logic steer_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (expire) begin
            flag_q <= 1'b1;
        end else if (wr_stat && !stat_keep) begin
            flag_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= 1'b0;
            steer_q <= 1'b0;
        end else if (expire) begin
            pulse_q <= 1'b1;
            steer_q <= steer_rst;
        end else if (tick_sel) begin
            pulse_q <= 1'b0;
        end
    end

    assign irq_o = pulse_q && !steer_q;
    assign rst_o = pulse_q && steer_q;
endmodule

// File: rtl/wdog_regblk.sv
module wdog_regblk
    import wdog_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h1B,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h0F
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    input  logic [NUM_TICKS-1:0] tick_stb,
    output logic                 irq_o,
    output logic                 rst_o
);
    logic             wr_ctrl;
    logic             wr_stat;
    logic             stat_keep;
    wdog_ctrl_t       new_ctrl;
    wdog_ctrl_t       ctrl_q;
    logic             armed;
    logic [CNT_W-1:0] cnt_q;
    logic             tick_sel;
    logic             expire;
    logic             flag_q;

    wdog_regfile #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR),
        .STAT_ADDR (STAT_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .flag_q    (flag_q),
        .rd_data   (rd_data),
        .wr_ctrl   (wr_ctrl),
        .wr_stat   (wr_stat),
        .stat_keep (stat_keep),
        .new_ctrl  (new_ctrl),
        .ctrl_q    (ctrl_q)
    );

    wdog_countdown u_cnt (
        .clk      (clk),
        .rst      (rst),
        .wr_ctrl  (wr_ctrl),
        .load_cnt (new_ctrl.count),
        .rate     (ctrl_q.rate),
        .tick_stb (tick_stb),
        .armed    (armed),
        .cnt_q    (cnt_q),
        .tick_sel (tick_sel),
        .expire   (expire)
    );

    wdog_expiry_out u_out (
        .clk       (clk),
        .rst       (rst),
        .expire    (expire),
        .tick_sel  (tick_sel),
        .steer_rst (ctrl_q.steer_rst),
        .wr_stat   (wr_stat),
        .stat_keep (stat_keep),
        .flag_q    (flag_q),
        .irq_o     (irq_o),
        .rst_o     (rst_o)
    );
endmodule

// File: rtl/wdog_regblk_chk.sv
module wdog_regblk_chk
    import wdog_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h1B,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h0F
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CNT_W-1:0]  wr_cnt,
    input logic              wr_keep,
    input logic              irq_o,
    input logic              rst_o,
    input logic              armed,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              flag_q,
    input logic              tick_sel
);
    logic is_ctrl_wr;
    logic is_stat_wr;
    assign is_ctrl_wr = wr_en && (wr_addr == CTRL_ADDR);
    assign is_stat_wr = wr_en && (wr_addr == STAT_ADDR);

    assert_reload_R3: assert property (@(posedge clk) disable iff (rst)
        (is_ctrl_wr && wr_cnt != '0) |=> (armed && cnt_q == $past(wr_cnt)));

    assert_zero_disarm_R4: assert property (@(posedge clk) disable iff (rst)
        (is_ctrl_wr && wr_cnt == '0) |=> !armed);

    assert_hold_no_tick_R5: assert property (@(posedge clk) disable iff (rst)
        (armed && !tick_sel && !is_ctrl_wr) |=> (armed && $stable(cnt_q)));

    assert_flag_source_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> ($past(armed) && $past(tick_sel) && $past(cnt_q) == CNT_W'(1)));

    assert_stays_stopped_R6: assert property (@(posedge clk) disable iff (rst)
        (!armed && !is_ctrl_wr) |=> !armed);

    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (is_stat_wr && !wr_keep && !(armed && tick_sel && cnt_q == CNT_W'(1))) |=> !flag_q);

    assert_pulse_source_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o || rst_o) |-> $past(armed));
endmodule

bind wdog_regblk wdog_regblk_chk #(
    .ADDR_W    (ADDR_W),
    .CTRL_ADDR (CTRL_ADDR),
    .STAT_ADDR (STAT_ADDR)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_cnt   (wr_data[CNT_LSB +: CNT_W]),
    .wr_keep  (wr_data[EXP_BIT]),
    .irq_o    (irq_o),
    .rst_o    (rst_o),
    .armed    (armed),
    .cnt_q    (cnt_q),
    .flag_q   (flag_q),
    .tick_sel (tick_sel)
);

// File: tb/wdog_regblk_test.sv
module wdog_regblk_test;
    localparam logic [7:0] A_CTRL = 8'h1B;
    localparam logic [7:0] A_STAT = 8'h0F;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [3:0] tick_stb = '0;
    logic       irq_o;
    logic       rst_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    wdog_regblk uut (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .tick_stb (tick_stb),
        .irq_o    (irq_o),
        .rst_o    (rst_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic [3:0] stb);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; tick_stb = stb;
        @(negedge clk);
        wr_en = 1'b0; tick_stb = '0;
    endtask

    task automatic strobe(input logic [3:0] m);
        @(negedge clk);
        tick_stb = m;
        @(negedge clk);
        tick_stb = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    // {irq_o, rst_o}: steering 1 -> 2'b01, steering 0 -> 2'b10
    function automatic logic [1:0] exp_outs(input bit steer);
        return steer ? 2'b01 : 2'b10;
    endfunction

    task automatic chk_flag(input string tag, input bit f);
        logic [7:0] v;
        rd(A_STAT, v);
        check(tag, v, {2'b00, f, 5'b00000});
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            report();
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 outputs", {irq_o, rst_o}, 2'b00);
        chk_flag("R1 status", 1'b0);
        rd(A_CTRL, v);
        check("R1 ctrl", v, 8'h00);
        for (int i = 0; i < 40; i++) strobe(4'hF);
        check("R1 no expiry when disarmed", {irq_o, rst_o}, 2'b00);
        chk_flag("R1 flag after strobes", 1'b0);

        // Sweep every rate, count and steering value
        for (int rate = 0; rate < 4; rate++) begin
            for (int cnt = 1; cnt < 32; cnt++) begin
                for (int st = 0; st < 2; st++) begin
                    logic [7:0] cv;
                    logic [3:0] sel;
                    cv  = {st[0], cnt[4:0], rate[1:0]};
                    sel = 4'b0001 << rate;
                    wr(A_CTRL, cv, 4'h0);
                    rd(A_CTRL, v);
                    check("R2 ctrl readback", v, cv);
                    for (int k = 1; k <= cnt; k++) begin
                        strobe(~sel);
                        if (k == cnt) begin
                            check("R5 other strobes ignored", {irq_o, rst_o}, 2'b00);
                            chk_flag("R5 flag before last tick", 1'b0);
                        end
                        strobe(sel);
                        if (k == cnt - 1) begin
                            check("R3 no early expiry", {irq_o, rst_o}, 2'b00);
                            chk_flag("R3 flag early", 1'b0);
                        end
                    end
                    check("R8 steered output", {irq_o, rst_o}, exp_outs(st[0]));
                    chk_flag("R6 flag set", 1'b1);
                    strobe(~sel);
                    check("R8 pulse held", {irq_o, rst_o}, exp_outs(st[0]));
                    strobe(sel);
                    check("R8 pulse ends", {irq_o, rst_o}, 2'b00);
                    for (int j = 0; j < 3; j++) strobe(sel);
                    check("R6 stopped", {irq_o, rst_o}, 2'b00);
                    wr(A_STAT, 8'h20, 4'h0);
                    chk_flag("R7 write 1 keeps", 1'b1);
                    wr(A_STAT, 8'h00, 4'h0);
                    chk_flag("R7 write 0 clears", 1'b0);
                end
            end
        end

        // R4 zero count disarms mid-count
        wr(A_CTRL, {1'b0, 5'd5, 2'd2}, 4'h0);
        strobe(4'h4); strobe(4'h4);
        wr(A_CTRL, 8'h02, 4'h0);
        for (int i = 0; i < 40; i++) strobe(4'h4);
        check("R4 no output", {irq_o, rst_o}, 2'b00);
        chk_flag("R4 no flag", 1'b0);

        // R3 rewrite restarts count
        wr(A_CTRL, {1'b0, 5'd3, 2'd2}, 4'h0);
        strobe(4'h4); strobe(4'h4);
        wr(A_CTRL, {1'b0, 5'd3, 2'd2}, 4'h0);
        strobe(4'h4); strobe(4'h4);
        chk_flag("R3 restart no flag", 1'b0);
        strobe(4'h4);
        check("R3 restart expiry", {irq_o, rst_o}, 2'b10);
        strobe(4'h4);
        wr(A_STAT, 8'h00, 4'h0);

        // R9 write against a selected strobe
        wr(A_CTRL, {1'b0, 5'd2, 2'd2}, 4'h4);
        strobe(4'h4);
        chk_flag("R9 no decrement on write", 1'b0);
        strobe(4'h4);
        chk_flag("R9 expiry after two", 1'b1);
        strobe(4'h4);
        wr(A_STAT, 8'h00, 4'h0);

        // R7 expiry beats a clearing write
        wr(A_CTRL, {1'b0, 5'd1, 2'd2}, 4'h0);
        wr(A_STAT, 8'h00, 4'h4);
        chk_flag("R7 expiry wins", 1'b1);
        strobe(4'h4);
        wr(A_STAT, 8'h00, 4'h0);
        chk_flag("R7 cleared", 1'b0);

        // R8 steering latched at expiry
        wr(A_CTRL, {1'b1, 5'd1, 2'd2}, 4'h0);
        strobe(4'h4);
        check("R8 reset output", {irq_o, rst_o}, 2'b01);
        wr(A_CTRL, 8'h02, 4'h0);
        check("R8 steering latched", {irq_o, rst_o}, 2'b01);
        strobe(4'h4);
        check("R8 pulse done", {irq_o, rst_o}, 2'b00);
        wr(A_STAT, 8'h00, 4'h0);

        // R10 stray addresses
        wr(A_CTRL, {1'b1, 5'd2, 2'd2}, 4'h0);
        wr(8'h1C, 8'hFF, 4'h0);
        wr(8'h00, 8'h00, 4'h0);
        wr(8'h1A, 8'h00, 4'h0);
        rd(A_CTRL, v);
        check("R10 ctrl unchanged", v, {1'b1, 5'd2, 2'd2});
        rd(8'h1C, v);
        check("R10 other read zero", v, 8'h00);
        strobe(4'h4);
        chk_flag("R10 count kept", 1'b0);
        strobe(4'h4);
        check("R10 expiry on schedule", {irq_o, rst_o}, 2'b01);
        chk_flag("R10 flag", 1'b1);
        wr(8'h0E, 8'h00, 4'h0);
        chk_flag("R10 flag unchanged", 1'b1);

        done = 1'b1;
        report();
        $finish;
    end
endmodule